// File: doc/BRIEF.md
# Lockable System Watchdog Timer

This block is a watchdog counter advanced by a slow timebase strobe. Software programs a single control byte that turns the watchdog on, picks one of four timeout lengths and chooses the action that follows a timeout. It must also write a restart bit periodically so the count never runs out. When the count does run out, the block raises a one-cycle request on one of two action outputs, either a power-off or a power-reset. It also sets a sticky timeout flag, which software clears by reading it.

A lock input, fixed while the block is in reset, hardens the watchdog against runaway software. When lock is high, software can still start the watchdog but cannot stop it. The surrounding logic supplies the timebase strobe (for example one strobe per second) and carries out the power action.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the watchdog is off and no action request or flag is active. The control byte reads back as bit 0 lock (the value of `lock_strap`), bit 1 enable, bit 2 restart (always 0), bit 3 action select, bits 5:4 timeout code, and bits 7:6 as 0. Bit 0 and bits 7:6 of a write have no effect.
- R2: Once started, the watchdog times out on the Nth strobe counted, with N = TICKS_BASE << code. Code 0/1/2/3 gives 16/32/64/128 units. The action request is visible in the cycle after the clock edge that samples the final strobe.
- R3: Writing 1 to bit 2 reloads the full timeout, including after a timeout has already occurred.
- R4: With lock low, writing 0 to the enable bit stops counting, so no timeout occurs. Writing 1 to the enable bit when it was 0 reloads the full timeout.
- R5: With lock high, a write with enable 0 leaves the watchdog running, and the other fields of that write still take effect. A write with enable 1 still starts the watchdog.
- R6: With action select 0 a timeout pulses `pwr_off_req`; with action select 1 it pulses `pwr_rst_req`. Each pulse lasts exactly one cycle, and the two never pulse together.
- R7: A timeout sets `exp_flag`, which then holds until a cycle with `flag_rd` high clears it. If a timeout and a read happen in the same cycle, the flag stays set.
- R8: After a timeout the count halts and no further request is issued until the watchdog is restarted (R3), re-enabled (R4), or given a new timeout code (R9).
- R9: Writing a timeout code different from the current one reloads the count with the new full timeout.
- R10: A strobe that arrives in the same cycle as a control write is not counted. A write that reloads nothing leaves the remaining count otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle per counted unit |
| lock_strap | input | 1 | Lock level, held constant outside reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte read value |
| flag_rd | input | 1 | Read strobe for the timeout flag; clears it |
| exp_flag | output | 1 | Sticky timeout flag |
| pwr_off_req | output | 1 | One-cycle power-off request |
| pwr_rst_req | output | 1 | One-cycle power-reset request |

## Verification
The embedded properties assume that `lock_strap` changes only while reset is asserted. The stimulus honours this by changing it only under reset. They also assume that a reloaded count is never shorter than two strobes, which the stimulus keeps by leaving TICKS_BASE at its default. The bench holds `tick` high in every cycle so that timeout distances are exact cycle counts. It places writes, reads and disables at chosen offsets within a count, including a read in the very cycle a timeout lands.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned PER_W   = 2;
  localparam int unsigned NUM_ACT = 2;

  // control byte field positions
  localparam int unsigned B_LOCK = 0;
  localparam int unsigned B_EN   = 1;
  localparam int unsigned B_CLR  = 2;
  localparam int unsigned B_MODE = 3;
  localparam int unsigned B_PER  = 4;

  typedef enum logic {
    ACT_OFF   = 1'b0,
    ACT_RESET = 1'b1
  } wdt_action_e;

  typedef struct packed {
    logic [PER_W-1:0] per;
    wdt_action_e      mode;
    logic             en;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output wdt_cfg_t          cfg_o,
  output logic [PER_W-1:0]  load_per_o,
  output logic              reload_o,
  output logic [CTRL_W-1:0] rdata_o
);

  wdt_cfg_t cfg_q;
  wdt_cfg_t cfg_d;
  logic     reload_d;
  logic     en_req;
  logic     unused_wr_bits;

  assign en_req         = wr_data_i[B_EN];
  assign unused_wr_bits = ^{wr_data_i[CTRL_W-1:B_PER+PER_W], wr_data_i[B_LOCK]};

  // next-state: lock only blocks the off-direction of enable
  always_comb begin
    cfg_d    = cfg_q;
    reload_d = 1'b0;
    if (wr_en_i) begin
      cfg_d.en   = lock_i ? (cfg_q.en | en_req) : en_req;
      cfg_d.mode = wdt_action_e'(wr_data_i[B_MODE]);
      cfg_d.per  = wr_data_i[B_PER +: PER_W];
      reload_d   = wr_data_i[B_CLR]
                 | (cfg_d.en & ~cfg_q.en)
                 | (cfg_d.per != cfg_q.per);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign load_per_o = cfg_d.per;
  assign reload_o   = reload_d;

  always_comb begin
    rdata_o                      = '0;
    rdata_o[B_LOCK]              = lock_i;
    rdata_o[B_EN]                = cfg_q.en;
    rdata_o[B_MODE]              = cfg_q.mode;
    rdata_o[B_PER +: PER_W]      = cfg_q.per;
  end

  // R5: locked watchdog never turns itself off
  a_r5_lock_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && cfg_q.en) |=> cfg_q.en);

  // R4: without a write the configuration is frozen
  a_r4_cfg_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_BASE = 16,
  localparam int unsigned CNT_W     = $clog2((TICKS_BASE << 3) + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [PER_W-1:0] load_per_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             active;
  logic             step;
  logic             cnt_ce;

  assign load_val = CNT_W'(TICKS_BASE << load_per_i);
  assign active   = en_i & (cnt_q != '0);
  assign step     = active & tick_i & ~hold_i;
  assign expire_o = step & (cnt_q == CNT_W'(1));
  assign cnt_ce   = reload_i | step;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: each counted strobe removes exactly one unit
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !hold_i && !reload_i && cnt_q > CNT_W'(1))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R8: a halted counter stays halted until reloaded
  a_r8_halt_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload_i) |=> (cnt_q == '0));

  // R9: a reload always arms a non-empty count
  a_r9_reload_arms: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q != '0));

  // R4: a disabled watchdog does not count
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !reload_i) |=> $stable(cnt_q));

  // R10: strobe in a write cycle is dropped
  a_r10_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !reload_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_event.sv
module wdt_event
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire_i,
  input  wdt_action_e        mode_i,
  input  logic               rd_clr_i,
  output logic [NUM_ACT-1:0] pulse_o,
  output logic               flag_o
);

  logic [NUM_ACT-1:0] pulse_q;
  logic [NUM_ACT-1:0] pulse_d;
  logic               flag_q;
  logic               flag_d;

  for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
    assign pulse_d[a] = expire_i & (int'(mode_i) == a);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q[a] <= 1'b0;
      end else begin
        pulse_q[a] <= pulse_d[a];
      end
    end

    // R6: an action request lasts one cycle
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q[a] |=> !pulse_q[a]);
  end

  // set has priority over the read-clear
  assign flag_d = expire_i | (flag_q & ~rd_clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;

  // R6: at most one action per timeout
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  // R7: flag persists until read, and a timeout always sets it
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_clr_i) |=> flag_q);

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);

  a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !expire_i) |=> !flag_q);

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_BASE = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lock_strap,
  input  logic        ctrl_wr,
  input  logic [7:0]  ctrl_wdata,
  output logic [7:0]  ctrl_rdata,
  input  logic        flag_rd,
  output logic        exp_flag,
  output logic        pwr_off_req,
  output logic        pwr_rst_req
);

  logic               rst_meta;
  logic               rst_sync_n;
  wdt_cfg_t           cfg;
  logic [PER_W-1:0]   load_per;
  logic               reload;
  logic               expire;
  logic [NUM_ACT-1:0] act_pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  wdt_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock_i     (lock_strap),
    .wr_en_i    (ctrl_wr),
    .wr_data_i  (ctrl_wdata),
    .cfg_o      (cfg),
    .load_per_o (load_per),
    .reload_o   (reload),
    .rdata_o    (ctrl_rdata)
  );

  wdt_counter #(
    .TICKS_BASE (TICKS_BASE)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick),
    .hold_i     (ctrl_wr),
    .en_i       (cfg.en),
    .reload_i   (reload),
    .load_per_i (load_per),
    .expire_o   (expire)
  );

  wdt_event u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .expire_i (expire),
    .mode_i   (cfg.mode),
    .rd_clr_i (flag_rd),
    .pulse_o  (act_pulse),
    .flag_o   (exp_flag)
  );

  assign pwr_off_req = act_pulse[ACT_OFF];
  assign pwr_rst_req = act_pulse[ACT_RESET];

  // R1: nothing is requested while reset is still being released
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |=> (!pwr_off_req && !pwr_rst_req && !exp_flag));

endmodule

// File: tb/wdt_lockable_bench.sv
module wdt_lockable_bench;

  localparam int BASE = 16;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       lock_strap;
  logic       ctrl_wr;
  logic [7:0] ctrl_wdata;
  logic [7:0] ctrl_rdata;
  logic       flag_rd;
  logic       exp_flag;
  logic       pwr_off_req;
  logic       pwr_rst_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wdt_lockable #(.TICKS_BASE(BASE)) u_wdt_lockable (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .lock_strap  (lock_strap),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .ctrl_rdata  (ctrl_rdata),
    .flag_rd     (flag_rd),
    .exp_flag    (exp_flag),
    .pwr_off_req (pwr_off_req),
    .pwr_rst_req (pwr_rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_en, m_mode, m_per, m_cnt, m_flag, m_off, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_per = 0; m_cnt = 0;
      m_flag = 0; m_off = 0; m_rst = 0;
    end else begin
      int newen;
      int newper;
      m_off = 0;
      m_rst = 0;
      if (flag_rd) m_flag = 0;
      if (ctrl_wr) begin
        newen  = lock_strap ? (m_en | int'(ctrl_wdata[1])) : int'(ctrl_wdata[1]);
        newper = int'(ctrl_wdata[5:4]);
        if (ctrl_wdata[2] || (newen == 1 && m_en == 0) || newper != m_per)
          m_cnt = BASE << newper;
        m_en   = newen;
        m_mode = int'(ctrl_wdata[3]);
        m_per  = newper;
      end else if (tick && m_en == 1 && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          if (m_mode == 1) m_rst = 1; else m_off = 1;
          m_flag = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 off request", int'(pwr_off_req), m_off);
      chk("R6 reset request", int'(pwr_rst_req), m_rst);
      chk("R7 flag", int'(exp_flag), m_flag);
      chk("R1 control readback", int'(ctrl_rdata),
          (m_per << 4) | (m_mode << 3) | (m_en << 1) | int'(lock_strap));
    end
  end

  // watchdog on the bench itself
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // caller sits at a negedge
  task automatic wr(input logic [7:0] d);
    ctrl_wr    = 1'b1;
    ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr    = 1'b0;
    ctrl_wdata = 8'h00;
  endtask

  task automatic rd_flag();
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic wait_pulse(output int n, output int was_rst);
    n = 0;
    while (!(pwr_off_req || pwr_rst_req) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    was_rst = int'(pwr_rst_req);
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwr_off_req || pwr_rst_req) seen++;
    end
  endtask

  task automatic do_reset(input logic lk);
    @(negedge clk);
    rst_n = 1'b0;
    lock_strap = lk;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    int w;
    int seen;
    rst_n = 1'b0; tick = 1'b1; lock_strap = 1'b0;
    ctrl_wr = 1'b0; ctrl_wdata = 8'h00; flag_rd = 1'b0;
    repeat (3) @(posedge clk);
    do_reset(1'b0);

    // R1 reset state and non-writable bits
    chk("R1 ctrl after reset", int'(ctrl_rdata), 0);
    chk("R1 flag after reset", int'(exp_flag), 0);
    chk("R1 no request after reset", int'(pwr_off_req | pwr_rst_req), 0);
    wr(8'h01);
    chk("R1 lock bit not writable", int'(ctrl_rdata), 0);

    // R2 every timeout code, R9 code change reloads a halted count
    for (int k = 0; k < 4; k++) begin
      wr(8'((k << 4) | 2));
      wait_pulse(n, w);
      chk("R2 timeout length", n, BASE << k);
      chk("R6 action off for select 0", w, 0);
      @(negedge clk);
      chk("R6 pulse is one cycle", int'(pwr_off_req), 0);
      chk("R7 flag set by timeout", int'(exp_flag), 1);
      rd_flag();
      chk("R7 flag cleared by read", int'(exp_flag), 0);
    end

    // R6 reset action; R9 code 3 -> 0 restarts
    wr(8'h0A);
    wait_pulse(n, w);
    chk("R9 new code reloads", n, BASE);
    chk("R6 action reset for select 1", w, 1);

    // R8 halted after timeout
    quiet(40, seen);
    chk("R8 no request after timeout", seen, 0);

    // R3 restart after timeout, R7 set beats read in the same cycle
    wr(8'h06);
    chk("R3 restart bit reads 0", int'(ctrl_rdata), 8'h02);
    repeat (15) @(negedge clk);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    chk("R3 restart reloads full timeout", int'(pwr_off_req), 1);
    chk("R7 set wins over read", int'(exp_flag), 1);
    rd_flag();
    chk("R7 flag cleared after read", int'(exp_flag), 0);

    // R3 restart in mid-count
    wr(8'h06);
    repeat (9) @(negedge clk);
    wr(8'h06);
    wait_pulse(n, w);
    chk("R3 mid-count restart", n, BASE);

    // R10 write without reload drops the strobe; reserved bits
    wr(8'h06);
    repeat (4) @(negedge clk);
    wr(8'hC2);
    chk("R10 reserved bits read 0", int'(ctrl_rdata), 8'h02);
    wait_pulse(n, w);
    chk("R10 strobe dropped in write cycle", n, BASE - 4);

    // R4 disable without lock, re-enable reloads
    wr(8'h06);
    repeat (4) @(negedge clk);
    wr(8'h00);
    chk("R4 enable cleared", int'(ctrl_rdata), 0);
    quiet(40, seen);
    chk("R4 disabled never times out", seen, 0);
    wr(8'h02);
    wait_pulse(n, w);
    chk("R4 re-enable reloads", n, BASE);

    // R5 locked behaviour
    do_reset(1'b1);
    chk("R5 lock reads back", int'(ctrl_rdata), 8'h01);
    wr(8'h02);
    chk("R5 locked enable allowed", int'(ctrl_rdata), 8'h03);
    repeat (2) @(negedge clk);
    wr(8'h08);
    chk("R5 disable ignored, mode taken", int'(ctrl_rdata), 8'h0B);
    wait_pulse(n, w);
    chk("R5 locked watchdog still expires", n, BASE - 2);
    chk("R5 mode from disabling write used", w, 1);
    wr(8'h00);
    chk("R5 enable survives zero write", int'(ctrl_rdata), 8'h03);
    wr(8'h04);
    wait_pulse(n, w);
    chk("R5 restart while locked", n, BASE);
    chk("R5 off action after mode change", w, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule